// File: doc/BRIEF.md
# Supply Monitor Reset Filter

This block watches a one-bit low-supply indication from an analog comparator and turns it into two results: a status flag that software can poll and a reset request for the chip's reset sequencer. The raw indication is first brought into the CPU clock domain through a synchronizer. A debounce with different attack and release times then filters it. The reset request asserts only after the supply has stayed low for a run of consecutive cycles. It releases after a single clean cycle.

Three configuration bits choose how the block behaves:
- `cfg_mon_en` powers the monitor as a whole.
- `cfg_rst_en` allows reset requests.
- `cfg_stop_en` keeps the monitor alive while the chip is in stop mode.

In stop mode there is no running filter clock to rely on, so the filter is bypassed and the synchronized trip drives the reset path directly. The status flag is also presented as bit 7 of a read-only status byte on a plain read data port. That port needs no handshake, because it has no data flow and nothing to back-pressure.

Top module: `supmon_filter`

## Requirements
- R1: While `por_n` is low, and after it is released with `trip_raw` at 0, `rst_req`, `low_flag` and `stat_rd_data` are all 0.
- R2: With monitor and reset enabled and `stop_mode` at 0, `rst_req` goes to 1 once the synchronized trip has been 1 for `FILT_CYCLES` (default 9) consecutive clock cycles. With the default two synchronizer stages, a constant 1 on `trip_raw` raises `rst_req` after the 11th rising edge and not after the 10th.
- R3: Once `rst_req` is 1 outside stop mode, one cycle of synchronized trip at 0 clears it. This is 3 rising edges after `trip_raw` falls: 2 for the synchronizer and 1 for the filter.
- R4: With `cfg_mon_en` at 0, `rst_req` and `low_flag` stay 0 whatever `trip_raw` does.
- R5: With `cfg_mon_en` at 1 and `cfg_rst_en` at 0, `low_flag` reports the trip and `rst_req` stays 0 however long the trip lasts.
- R6: `stat_rd_data[7]` equals `low_flag`, and `stat_rd_data[6:0]` always reads 0.
- R7: With `stop_mode` at 1 and `cfg_stop_en` at 1, the filter is bypassed: `rst_req` equals the synchronized trip, so it is 1 after the 2nd rising edge following a rise of `trip_raw` and not after the 1st.
- R8: With `stop_mode` at 1 and `cfg_stop_en` at 0, `rst_req` and `low_flag` are held at 0.
- R9: Any cycle of synchronized trip at 0 restarts the consecutive count, so two bursts of `FILT_CYCLES-1` cycles separated by a clean gap raise no reset. The count saturates instead of wrapping, so a trip held for many times `FILT_CYCLES` keeps `rst_req` at 1.
- R10: With the monitor active, `low_flag` follows the synchronized, unfiltered trip. It changes after the 2nd rising edge following a change on `trip_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| trip_raw | input | 1 | Comparator output: 1 = supply below trip level |
| cfg_mon_en | input | 1 | Monitor power enable |
| cfg_rst_en | input | 1 | Reset request enable |
| cfg_stop_en | input | 1 | Keep monitor active in stop mode |
| stop_mode | input | 1 | Chip is in stop mode |
| rst_req | output | 1 | Reset request to the reset sequencer |
| low_flag | output | 1 | Low-supply status bit |
| stat_rd_data | output | 8 | Status byte: low flag in bit 7, zeros below |

## Verification
The bench builds the block with its defaults: a count of nine and two synchronizer stages. With those values, the attack edge falls at edge 11 and the release at edge 3 after a change on the raw input, so both can be checked on the exact cycle. A hold of nine cycles reaches the saturation point within a few dozen cycles, so the bench can test runs that are one short of the threshold, runs exactly at it, and holds far past it. The same short runs also reach the stop-mode bypass timing, which needs only two edges.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  // Effective operating mode of the monitor
  typedef enum logic [1:0] {
    MON_OFF    = 2'd0,  // powered down or parked in stop
    MON_FILTER = 2'd1,  // run mode, debounce active
    MON_BYPASS = 2'd2   // stop mode, filter bypassed
  } mon_mode_e;

  localparam int STAT_W    = 8;
  localparam int FLAG_BIT  = 7;

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= 1'b0;
          else        chain[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];

endmodule

// File: rtl/supmon_debounce.sv
module supmon_debounce #(
  parameter int HOLD = 9
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,      // filter allowed to count
  input  logic level,    // synchronized trip
  output logic held      // level has been high HOLD cycles
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_cnt <= '0;
    end else if (!run || !level) begin
      run_cnt <= '0;
    end else if (run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign held = (run_cnt == LIMIT);

endmodule

// File: rtl/supmon_filter.sv
module supmon_filter
  import supmon_pkg::*;
#(
  parameter int FILT_CYCLES = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              trip_raw,
  input  logic              cfg_mon_en,
  input  logic              cfg_rst_en,
  input  logic              cfg_stop_en,
  input  logic              stop_mode,
  output logic              rst_req,
  output logic              low_flag,
  output logic [STAT_W-1:0] stat_rd_data
);

  logic      trip_s;
  logic      filt_held;
  mon_mode_e mode;

  supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d_in  (trip_raw),
    .q_out (trip_s)
  );

  always_comb begin
    if (!cfg_mon_en)                  mode = MON_OFF;
    else if (stop_mode && cfg_stop_en) mode = MON_BYPASS;
    else if (stop_mode)               mode = MON_OFF;
    else                              mode = MON_FILTER;
  end

  supmon_debounce #(.HOLD(FILT_CYCLES)) u_deb (
    .clk   (clk),
    .por_n (por_n),
    .run   (mode == MON_FILTER),
    .level (trip_s),
    .held  (filt_held)
  );

  always_comb begin
    unique case (mode)
      MON_FILTER: rst_req = cfg_rst_en & filt_held;
      MON_BYPASS: rst_req = cfg_rst_en & trip_s;
      default:    rst_req = 1'b0;
    endcase
  end

  assign low_flag = (mode != MON_OFF) & trip_s;

  always_comb begin
    stat_rd_data           = '0;
    stat_rd_data[FLAG_BIT] = low_flag;
  end

endmodule

// File: rtl/supmon_filter_chk.sv
module supmon_filter_chk (
  input logic       clk,
  input logic       por_n,
  input logic       cfg_mon_en,
  input logic       cfg_rst_en,
  input logic       cfg_stop_en,
  input logic       stop_mode,
  input logic       trip_s,
  input logic       rst_req,
  input logic       low_flag,
  input logic [7:0] stat_rd_data
);

  // R4
  mon_off_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_mon_en |-> (!rst_req && !low_flag));

  // R5
  poll_no_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_rst_en |-> !rst_req);

  // R6
  stat_pad_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (stat_rd_data[6:0] == 7'd0) && (stat_rd_data[7] == low_flag));

  // R8
  stop_parked_chk: assert property (@(posedge clk) disable iff (!por_n)
    (stop_mode && !cfg_stop_en) |-> (!rst_req && !low_flag));

  // R3
  clean_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_mon_en && !stop_mode && !trip_s) |=> (!rst_req || stop_mode));

  // R2
  rise_needs_trip_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_req) && !stop_mode) |-> $past(trip_s));

endmodule

bind supmon_filter supmon_filter_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .cfg_mon_en   (cfg_mon_en),
  .cfg_rst_en   (cfg_rst_en),
  .cfg_stop_en  (cfg_stop_en),
  .stop_mode    (stop_mode),
  .trip_s       (trip_s),
  .rst_req      (rst_req),
  .low_flag     (low_flag),
  .stat_rd_data (stat_rd_data)
);

// File: tb/supmon_filter_tb.sv
module supmon_filter_tb;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       trip_raw = 1'b0;
  logic       cfg_mon_en = 1'b0;
  logic       cfg_rst_en = 1'b0;
  logic       cfg_stop_en = 1'b0;
  logic       stop_mode = 1'b0;
  logic       rst_req;
  logic       low_flag;
  logic [7:0] stat_rd_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  supmon_filter u_dut (
    .clk          (clk),
    .por_n        (por_n),
    .trip_raw     (trip_raw),
    .cfg_mon_en   (cfg_mon_en),
    .cfg_rst_en   (cfg_rst_en),
    .cfg_stop_en  (cfg_stop_en),
    .stop_mode    (stop_mode),
    .rst_req      (rst_req),
    .low_flag     (low_flag),
    .stat_rd_data (stat_rd_data)
  );

  // vector: {mon, rst, stop_en, stop, trip, edges[5:0], exp_rst, exp_flag}
  localparam int NV = 8;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {5'b11001, 6'd10, 2'b01},  // R2 one edge short
    {5'b11001, 6'd11, 2'b11},  // R2 threshold reached
    {5'b10001, 6'd20, 2'b01},  // R5 polling only
    {5'b01001, 6'd20, 2'b00},  // R4 monitor off
    {5'b11011, 6'd2,  2'b00},  // R8 stop, not kept alive
    {5'b11111, 6'd2,  2'b11},  // R7 bypass after 2 edges
    {5'b11111, 6'd1,  2'b00},  // R7 not after 1 edge
    {5'b11000, 6'd5,  2'b00}   // R10 quiet supply
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    cfg_mon_en = 1'b1; cfg_rst_en = 1'b1; cfg_stop_en = 1'b0;
    stop_mode = 1'b0;  trip_raw = 1'b0;
    edges(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    edges(2);
    chk("R1", "rst_req in por", {7'd0, rst_req}, 8'd0);
    chk("R1", "stat in por", stat_rd_data, 8'd0);
    por_n = 1'b1;
    edges(2);
    chk("R1", "rst_req after por", {7'd0, rst_req}, 8'd0);
    chk("R1", "flag after por", {7'd0, low_flag}, 8'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      settle();
      {cfg_mon_en, cfg_rst_en, cfg_stop_en, stop_mode, trip_raw} = VEC[v][12:8];
      edges(int'(VEC[v][7:2]));
      chk($sformatf("vec%0d R2/R4/R5/R7/R8", v), "rst_req",
          {7'd0, rst_req}, {7'd0, VEC[v][1]});
      chk($sformatf("vec%0d R10", v), "low_flag",
          {7'd0, low_flag}, {7'd0, VEC[v][0]});
      chk($sformatf("vec%0d R6", v), "stat_rd_data",
          stat_rd_data, {VEC[v][0], 7'd0});
    end

    // R3: release after one clean cycle
    settle();
    trip_raw = 1'b1;
    edges(11);
    chk("R3", "armed", {7'd0, rst_req}, 8'd1);
    trip_raw = 1'b0;
    edges(2);
    chk("R3", "held 2 edges after drop", {7'd0, rst_req}, 8'd1);
    chk("R10", "flag falls 2 edges after drop", {7'd0, low_flag}, 8'd0);
    edges(1);
    chk("R3", "released 3 edges after drop", {7'd0, rst_req}, 8'd0);

    // R9: two short bursts separated by one clean cycle
    settle();
    trip_raw = 1'b1;
    edges(8);
    trip_raw = 1'b0;
    edges(1);
    trip_raw = 1'b1;
    edges(8);
    chk("R9", "bursts no reset", {7'd0, rst_req}, 8'd0);
    edges(3);
    chk("R9", "restarted count completes", {7'd0, rst_req}, 8'd1);

    // R9: saturation over a long hold
    settle();
    trip_raw = 1'b1;
    edges(200);
    chk("R9", "long hold keeps reset", {7'd0, rst_req}, 8'd1);
    trip_raw = 1'b0;
    edges(3);
    chk("R9", "release after long hold", {7'd0, rst_req}, 8'd0);

    // R4: monitor turned off while a reset is pending
    settle();
    trip_raw = 1'b1;
    edges(12);
    cfg_mon_en = 1'b0;
    #1;
    chk("R4", "off drops reset", {7'd0, rst_req}, 8'd0);
    chk("R4", "off drops flag", stat_rd_data, 8'd0);

    // R1: asynchronous por mid-run
    settle();
    trip_raw = 1'b1;
    edges(12);
    chk("R1", "pending before por", {7'd0, rst_req}, 8'd1);
    #1 por_n = 1'b0;
    #1;
    chk("R1", "async clear rst_req", {7'd0, rst_req}, 8'd0);
    chk("R1", "async clear flag", {7'd0, low_flag}, 8'd0);
    por_n = 1'b1;
    trip_raw = 1'b0;
    edges(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule